// File: doc/BRIEF.md
# Buck Soft-Start Off-Time Sequencer

This block chooses the switch off-time for every cycle while a current-mode buck stage powers up. A start pulse loads a soft-start counter with the longest allowed off-time. Each completed switching cycle then lowers that counter. The counter drops by a large step while the inductor current still falls to zero inside a cycle (discontinuous conduction). It drops by a small step once a cycle ends with no zero-cross seen (continuous conduction). When the counter reaches zero, soft start has no further effect, and the off-time requested by the feedback path is used alone.

The off-time that is applied is the larger of the soft-start counter and the feedback request, limited to the range from the minimum off-time to the maximum off-time. All values are in clock ticks. The defaults at a 50 MHz clock are 65 ticks (1.3 µs) for the maximum and 43 ticks (about 850 ns) for the minimum. A restart request returns the block to the fast phase with the counter reloaded, whatever phase it is in.

The controller has four states. IDLE waits for a start pulse (IDLE→FAST on start). FAST ramps down by the large step and moves to SLOW on the first cycle without a zero-cross (FAST→SLOW), or to STEADY if the counter reaches zero (FAST→STEADY). SLOW ramps down by the small step and moves to STEADY at zero (SLOW→STEADY). STEADY passes the feedback value through. A restart takes any state to FAST (restart→FAST).

Top module: `ssq_offtime_seq`

## Requirements
- R1: After reset the phase output is IDLE (encoding 0), and toff_o equals the maximum off-time for as long as the block stays idle.
- R2: A start pulse in IDLE moves the phase to FAST (encoding 1) and loads the soft-start counter with the maximum off-time.
- R3: In FAST, a cycle end with zero-cross seen lowers the counter by the fast step. The counter saturates at zero.
- R4: In FAST, a cycle end with no zero-cross moves the phase to SLOW (encoding 2) and lowers the counter by the slow step in that same cycle.
- R5: In SLOW, every cycle end lowers the counter by the slow step, whatever the zero-cross flag shows. A zero-cross never returns the block to FAST.
- R6: When the counter reaches zero, the phase becomes STEADY (encoding 3). From then on toff_o is the feedback request clamped to the range from the minimum to the maximum off-time.
- R7: In FAST and SLOW, toff_o is the larger of the counter and the feedback request, clamped to the range from the minimum to the maximum off-time.
- R8: A restart pulse in any phase moves the phase to FAST and reloads the counter with the maximum off-time.
- R9: A start pulse outside IDLE has no effect on the phase or the counter.
- R10: Without a cycle end, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins soft start from IDLE |
| restart_i | input | 1 | One-cycle pulse that reloads the ramp and enters FAST from any phase |
| cycle_end_i | input | 1 | One-cycle pulse at the end of each switching cycle |
| zc_seen_i | input | 1 | Inductor zero-cross was detected in the cycle that is ending |
| fb_toff_i | input | TW | Off-time requested by the feedback path, in ticks |
| toff_o | output | TW | Off-time to apply in the next cycle, in ticks |
| phase_o | output | 2 | Phase: 0 IDLE, 1 FAST, 2 SLOW, 3 STEADY |

## Verification
The ramp is driven with runs of cycles that all show a zero-cross, so it falls by the fast step until it saturates at zero and jumps from FAST straight to STEADY. A separate run has the zero-cross disappear part way through; this shows whether the step size switches on that exact cycle, and whether a zero-cross that comes back later is ignored in SLOW. The feedback request is set below the minimum, between the counter and the maximum, and above the maximum, which tests the larger-of selection and both clamps. Pulses that must do nothing are also applied: a start outside IDLE, and idle cycles with no cycle end. Restarts are issued from FAST, SLOW and STEADY.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FAST   = 2'd1,
        PH_SLOW   = 2'd2,
        PH_STEADY = 2'd3
    } ssq_phase_t;
endpackage

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
    parameter int TW        = 7,
    parameter int TOFF_MAX  = 65,
    parameter int FAST_STEP = 8,
    parameter int SLOW_STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          dec_fast_i,
    input  logic          dec_slow_i,
    output logic [TW-1:0] ss_o,
    output logic          empty_after_fast_o,
    output logic          empty_after_slow_o
);
    localparam logic [TW-1:0] LOAD_V = TW'(TOFF_MAX);
    localparam logic [TW-1:0] FSTEP  = TW'(FAST_STEP);
    localparam logic [TW-1:0] SSTEP  = TW'(SLOW_STEP);

    logic [TW-1:0] ss_q;
    logic [TW-1:0] after_fast;
    logic [TW-1:0] after_slow;

    always_comb begin
        after_fast = (ss_q > FSTEP) ? (ss_q - FSTEP) : '0;
        after_slow = (ss_q > SSTEP) ? (ss_q - SSTEP) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ss_q <= '0;
        else if (load_i)     ss_q <= LOAD_V;
        else if (dec_fast_i) ss_q <= after_fast;
        else if (dec_slow_i) ss_q <= after_slow;
    end

    assign ss_o               = ss_q;
    assign empty_after_fast_o = (after_fast == '0);
    assign empty_after_slow_o = (after_slow == '0);

    AST_RAMP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (ss_q <= $past(ss_q))); // R3
    AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !dec_fast_i && !dec_slow_i) |=> $stable(ss_q)); // R10
endmodule

// File: rtl/ssq_phase_fsm.sv
module ssq_phase_fsm
    import ssq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       restart_i,
    input  logic       cycle_end_i,
    input  logic       zc_seen_i,
    input  logic       empty_after_fast_i,
    input  logic       empty_after_slow_i,
    output ssq_phase_t phase_o,
    output logic       load_o,
    output logic       dec_fast_o,
    output logic       dec_slow_o
);
    ssq_phase_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        dec_fast_o = 1'b0;
        dec_slow_o = 1'b0;
        if (restart_i) begin
            load_o  = 1'b1;
            state_d = PH_FAST;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (start_i) begin
                        load_o  = 1'b1;
                        state_d = PH_FAST;
                    end
                end
                PH_FAST: begin
                    if (cycle_end_i && zc_seen_i) begin
                        dec_fast_o = 1'b1;
                        state_d    = empty_after_fast_i ? PH_STEADY : PH_FAST;
                    end else if (cycle_end_i) begin
                        dec_slow_o = 1'b1;
                        state_d    = empty_after_slow_i ? PH_STEADY : PH_SLOW;
                    end
                end
                PH_SLOW: begin
                    if (cycle_end_i) begin
                        dec_slow_o = 1'b1;
                        state_d    = empty_after_slow_i ? PH_STEADY : PH_SLOW;
                    end
                end
                PH_STEADY: begin
                    state_d = PH_STEADY;
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    assign phase_o = state_q;

    AST_SLOW_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SLOW && !restart_i) |=> (state_q != PH_FAST)); // R5
    AST_RESTART_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state_q == PH_FAST)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !restart_i && state_q == PH_STEADY) |=> (state_q == PH_STEADY)); // R9
endmodule

// File: rtl/ssq_toff_select.sv
module ssq_toff_select
    import ssq_pkg::*;
#(
    parameter int TW       = 7,
    parameter int TOFF_MIN = 43,
    parameter int TOFF_MAX = 65
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ssq_phase_t    phase_i,
    input  logic [TW-1:0] ss_i,
    input  logic [TW-1:0] fb_i,
    output logic [TW-1:0] toff_o
);
    localparam logic [TW-1:0] LO = TW'(TOFF_MIN);
    localparam logic [TW-1:0] HI = TW'(TOFF_MAX);

    logic [TW-1:0] pick;

    always_comb begin
        unique case (phase_i)
            PH_IDLE:   pick = HI;
            PH_STEADY: pick = fb_i;
            default:   pick = (ss_i > fb_i) ? ss_i : fb_i;
        endcase
        if (pick < LO)      toff_o = LO;
        else if (pick > HI) toff_o = HI;
        else                toff_o = pick;
    end

    AST_TOFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (toff_o >= LO) && (toff_o <= HI)); // R7
    AST_TOFF_COVERS_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_FAST || phase_i == PH_SLOW) |-> (toff_o >= ss_i || toff_o == HI)); // R7
endmodule

// File: rtl/ssq_offtime_seq.sv
module ssq_offtime_seq
    import ssq_pkg::*;
#(
    parameter int TOFF_MAX  = 65,
    parameter int TOFF_MIN  = 43,
    parameter int FAST_STEP = 8,
    parameter int SLOW_STEP = 2,
    parameter int TW        = $clog2(TOFF_MAX + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          restart_i,
    input  logic          cycle_end_i,
    input  logic          zc_seen_i,
    input  logic [TW-1:0] fb_toff_i,
    output logic [TW-1:0] toff_o,
    output logic [1:0]    phase_o
);
    ssq_phase_t    phase;
    logic          load, dec_fast, dec_slow;
    logic          empty_fast, empty_slow;
    logic [TW-1:0] ss;

    ssq_phase_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .start_i           (start_i),
        .restart_i         (restart_i),
        .cycle_end_i       (cycle_end_i),
        .zc_seen_i         (zc_seen_i),
        .empty_after_fast_i(empty_fast),
        .empty_after_slow_i(empty_slow),
        .phase_o           (phase),
        .load_o            (load),
        .dec_fast_o        (dec_fast),
        .dec_slow_o        (dec_slow)
    );

    ssq_ramp #(
        .TW(TW), .TOFF_MAX(TOFF_MAX), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)
    ) u_ramp (
        .clk               (clk),
        .rst_n             (rst_n),
        .load_i            (load),
        .dec_fast_i        (dec_fast),
        .dec_slow_i        (dec_slow),
        .ss_o              (ss),
        .empty_after_fast_o(empty_fast),
        .empty_after_slow_o(empty_slow)
    );

    ssq_toff_select #(
        .TW(TW), .TOFF_MIN(TOFF_MIN), .TOFF_MAX(TOFF_MAX)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase),
        .ss_i   (ss),
        .fb_i   (fb_toff_i),
        .toff_o (toff_o)
    );

    assign phase_o = phase;

    AST_STEADY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEADY) |-> (ss == '0)); // R6
    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && phase == PH_IDLE) |=> (ss == TW'(TOFF_MAX) && phase == PH_FAST)); // R2
endmodule

// File: tb/tb_ssq_offtime_seq.sv
module tb_ssq_offtime_seq;
    localparam int MAXV = 65;
    localparam int MINV = 43;
    localparam int FST  = 8;
    localparam int SST  = 2;
    localparam int TW   = $clog2(MAXV + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, restart_i = 1'b0, cycle_end_i = 1'b0, zc_seen_i = 1'b0;
    logic [TW-1:0] fb_toff_i = '0;
    logic [TW-1:0] toff_o;
    logic [1:0]    phase_o;

    always #10 clk = ~clk;

    ssq_offtime_seq #(.TOFF_MAX(MAXV), .TOFF_MIN(MINV), .FAST_STEP(FST), .SLOW_STEP(SST)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .restart_i(restart_i),
        .cycle_end_i(cycle_end_i), .zc_seen_i(zc_seen_i), .fb_toff_i(fb_toff_i),
        .toff_o(toff_o), .phase_o(phase_o)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    int q_toff[$];
    int q_ph[$];
    string q_tag[$];

    int m_ss = 0;
    int m_ph = 0;

    function automatic int clampv(int v);
        if (v < MINV) return MINV;
        if (v > MAXV) return MAXV;
        return v;
    endfunction

    function automatic int subsat(int v, int s);
        return (v > s) ? v - s : 0;
    endfunction

    task automatic step(input bit st, input bit rs, input bit ce, input bit zc,
                        input int fb, input string tag);
        int et;
        @(posedge clk); #2;
        start_i = st; restart_i = rs; cycle_end_i = ce; zc_seen_i = zc;
        fb_toff_i = TW'(fb);
        if (rs) begin
            m_ph = 1; m_ss = MAXV;
        end else if (st && m_ph == 0) begin
            m_ph = 1; m_ss = MAXV;
        end else if (ce && m_ph == 1) begin
            if (zc) m_ss = subsat(m_ss, FST);
            else begin m_ss = subsat(m_ss, SST); m_ph = 2; end
            if (m_ss == 0) m_ph = 3;
        end else if (ce && m_ph == 2) begin
            m_ss = subsat(m_ss, SST);
            if (m_ss == 0) m_ph = 3;
        end
        @(posedge clk); #2;
        start_i = 0; restart_i = 0; cycle_end_i = 0; zc_seen_i = 0;
        if (m_ph == 0)      et = MAXV;
        else if (m_ph == 3) et = clampv(fb);
        else                et = clampv((m_ss > fb) ? m_ss : fb);
        q_toff.push_back(et);
        q_ph.push_back(m_ph);
        q_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (q_toff.size() > 0) begin
            int et, ep;
            string tg;
            et = q_toff.pop_front();
            ep = q_ph.pop_front();
            tg = q_tag.pop_front();
            n_run++;
            if (int'(toff_o) != et || int'(phase_o) != ep) begin
                n_fail++;
                $display("FAIL %s: toff=%0d phase=%0d expected toff=%0d phase=%0d",
                         tg, toff_o, phase_o, et, ep);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if (phase_o != 2'd0 || int'(toff_o) != MAXV) begin
            n_fail++;
            $display("FAIL R1: toff=%0d phase=%0d expected toff=%0d phase=0", toff_o, phase_o, MAXV);
        end
        step(0, 0, 1, 1, 0, "R1 idle ignores cycle end");
        step(1, 0, 0, 0, 0, "R2 start loads max");
        step(0, 0, 1, 1, 0, "R3 fast step");
        step(0, 0, 1, 1, 0, "R3 fast step");
        step(0, 0, 1, 1, 0, "R3 fast step below min clamps R7");
        step(0, 0, 0, 0, 50, "R10 no cycle end holds, R7 fb larger");
        step(0, 0, 0, 1, 200, "R7 clamp at max");
        step(1, 0, 0, 0, 0, "R9 start ignored in fast");
        step(0, 0, 1, 0, 0, "R4 no zero-cross enters slow");
        step(0, 0, 1, 1, 0, "R5 zero-cross in slow stays slow");
        step(1, 0, 0, 0, 30, "R9 start ignored in slow");
        for (int i = 0; i < 18; i++) step(0, 0, 1, i[0], 0, "R5 slow ramp");
        step(0, 0, 1, 0, 0, "R6 reaches zero");
        step(0, 0, 0, 0, 50, "R6 steady follows feedback");
        step(0, 0, 1, 1, 10, "R6 steady clamps at min");
        step(0, 0, 0, 0, 250, "R6 steady clamps at max");
        step(1, 0, 0, 0, 0, "R9 start ignored in steady");
        step(0, 1, 0, 0, 0, "R8 restart from steady");
        for (int i = 0; i < 9; i++) step(0, 0, 1, 1, 0, "R3 fast ramp to zero saturates R6");
        step(0, 1, 0, 0, 0, "R8 restart again");
        step(0, 0, 1, 0, 60, "R4 slow entry with feedback");
        step(0, 1, 1, 1, 0, "R8 restart from slow beats cycle end");
        step(0, 0, 1, 1, 0, "R3 fast after restart");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule